// File: doc/BRIEF.md
# Integration Period Countdown Timer

This block sets how long a sensor's analog front end integrates before each conversion. Software writes an 8-bit setting through a simple write port. A nonzero setting is read as the two's complement of a count of base intervals. A prescaler divides the system clock into base intervals of `TICKS_PER_INTERVAL` clocks each, and a down-counter tracks how many intervals of the current period remain. When the last interval expires, the block emits a one-clock `done` pulse and at once starts the next period. The `integrating` flag stays high with no gap between periods.

A setting of zero does not mean a zero-length period. It selects manual gating, in which an external `gate` input marks when integration runs. While `enable` is low the block is idle: it does not integrate and it does not signal completion. The period length is captured when each period starts, so a new setting written mid-period applies from the following period.

Top module: `integ_timer`

## Requirements
- R1: After reset the stored setting is 0x00 (manual mode), `integrating` is low and `done` is low.
- R2: With a nonzero setting V, a period lasts N × `TICKS_PER_INTERVAL` clocks, where N = (256 − V) mod 256. `done` goes high exactly that many clocks after `integrating` goes high. `integrating` goes high one clock after `enable` is sampled high. `TICKS_PER_INTERVAL` must be at least 2.
- R3: The setting decodes as follows: 0xFF is 1 interval, 0xFE is 2, 0xED is 19, 0xDB is 37, 0xB6 is 74, 0x6C is 148, and 0x01 is 255, the longest.
- R4: `done` is high for exactly one clock. In automatic mode the next period starts without a gap: `integrating` stays high and the next `done` follows N × `TICKS_PER_INTERVAL` clocks later.
- R5: A write of the setting during a period does not change that period's length. The new value takes effect from the next period.
- R6: While `enable` is low, `integrating` is low from the next clock on and no `done` is produced. A period cut short this way is dropped, and a full-length period starts when `enable` returns high.
- R7: With setting 0x00 and `enable` high, `integrating` goes high one clock after `gate` is sampled high and stays high while `gate` stays high.
- R8: In manual mode, one clock after `gate` is sampled low, `done` pulses for one clock and `integrating` falls.
- R9: In automatic mode the `gate` input has no effect: toggling it does not change when `done` occurs.
- R10: If `enable` drops during a manual integration, the integration is dropped without a `done` pulse, even when `gate` falls later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wdata | input | 8 | Period setting to store |
| cfg_we | input | 1 | Write strobe for the setting |
| enable | input | 1 | Allows integration periods to run |
| gate | input | 1 | External integration gate, used in manual mode |
| integrating | output | 1 | High while a period is in progress |
| done | output | 1 | One-clock pulse at the end of each period |

## Verification
If the interval counter is wrong, or the wrong value is loaded at a restart, the error appears as a `done` pulse in the wrong place. It shows at the first period end, within N × `TICKS_PER_INTERVAL` clocks of `integrating` rising. The bench therefore measures that spacing for several settings and across consecutive periods. An error in the mode or state logic shows within one or two clocks, as an `integrating` flag that does not follow `enable` or `gate`, or as a `done` pulse where none may appear. The bench samples exactly those cycles after each change to `enable` or `gate`.

// File: rtl/integ_timer_pkg.sv
package integ_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_AUTO = 2'd1,
        ST_MAN  = 2'd2
    } integ_state_e;

    localparam int unsigned SET_W = 8;

    typedef struct packed {
        integ_state_e     state;
        logic [SET_W-1:0] setting;
        logic             done;
    } integ_ctl_t;

endpackage

// File: rtl/integ_prescaler.sv
module integ_prescaler #(
    parameter int unsigned TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && (pre_q == LAST);
        pre_d = pre_q;
        if (!run) begin
            pre_d = '0;
        end else if (tick) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R2: interval boundaries are never adjacent when TICKS >= 2
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/integ_intcount.sv
module integ_intcount #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load) begin
            rem_d = load_val;
        end else if (dec) begin
            rem_d = rem_q - 1'b1;
        end
        last = (rem_q == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    // R2: a running period always has intervals left to count
    assert_count_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rem_q != '0));

endmodule

// File: rtl/integ_timer.sv
module integ_timer
    import integ_timer_pkg::*;
#(
    parameter int unsigned TICKS_PER_INTERVAL = 270000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg_wdata,
    input  logic       cfg_we,
    input  logic       enable,
    input  logic       gate,
    output logic       integrating,
    output logic       done
);
    integ_ctl_t       ctl_d, ctl_q;
    logic             tick, last, load;
    logic [SET_W-1:0] load_val;
    logic             auto_run;

    assign auto_run = (ctl_q.state == ST_AUTO);
    assign load_val = SET_W'(0) - ctl_q.setting;

    integ_prescaler #(.TICKS(TICKS_PER_INTERVAL)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (auto_run),
        .tick (tick)
    );

    integ_intcount #(.CW(SET_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (auto_run),
        .load    (load),
        .load_val(load_val),
        .dec     (tick),
        .last    (last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load       = 1'b0;
        if (cfg_we) begin
            ctl_d.setting = cfg_wdata;
        end
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (enable) begin
                    if (ctl_q.setting != '0) begin
                        ctl_d.state = ST_AUTO;
                        load        = 1'b1;
                    end else if (gate) begin
                        ctl_d.state = ST_MAN;
                    end
                end
            end
            ST_AUTO: begin
                if (!enable) begin
                    ctl_d.state = ST_IDLE;
                end else if (tick && last) begin
                    ctl_d.done = 1'b1;
                    if (ctl_q.setting != '0) begin
                        load = 1'b1;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            ST_MAN: begin
                if (!enable) begin
                    ctl_d.state = ST_IDLE;
                end else if (!gate) begin
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.setting <= '0;
            ctl_q.done    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign integrating = (ctl_q.state != ST_IDLE);
    assign done        = ctl_q.done;

    // R6: a low enable clears the integrating flag on the next clock
    assert_idle_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !integrating);

    // R4: completion pulse is one clock wide
    assert_done_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: completion only ends a period that was running
    assert_done_after_integ_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(integrating));

    // R8: manual completion follows a low gate
    assert_man_done_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(ctl_q.state == ST_MAN)) |-> !$past(gate));

endmodule

// File: tb/integ_timer_test.sv
module integ_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       cfg_we = 1'b0;
    logic       enable = 1'b0;
    logic       gate = 1'b0;
    logic       integrating, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    integ_timer #(.TICKS_PER_INTERVAL(P)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
        .enable(enable), .gate(gate), .integrating(integrating), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ivals(input logic [7:0] v);
        return (256 - int'(v)) % 256;
    endfunction

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // waits for a done pulse, returns the clocks waited
    task automatic clocks_to_done(input bit toggle_gate, output int cnt);
        cnt = 0;
        while (cnt < 3000) begin
            @(negedge clk);
            if (toggle_gate) gate = ~gate;
            cnt++;
            if (done) break;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(integrating == 1'b0, "R1 integrating", int'(integrating), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        // stored setting is 0: enable with gate low must not start a period
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(integrating == 1'b0, "R1 reset setting manual", int'(integrating), 0);
        enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_auto_period(input logic [7:0] v, input string req);
        int c1, c2;
        write_reg(v);
        enable = 1'b1;
        @(negedge clk);
        chk(integrating == 1'b1, "R2 start latency", int'(integrating), 1);
        clocks_to_done(1'b0, c1);
        chk(c1 == ivals(v) * P, req, c1, ivals(v) * P);
        @(negedge clk);
        chk(done == 1'b0, "R4 one clock done", int'(done), 0);
        chk(integrating == 1'b1, "R4 no gap", int'(integrating), 1);
        clocks_to_done(1'b0, c2);
        chk(c2 + 1 == ivals(v) * P, "R4 back to back period", c2 + 1, ivals(v) * P);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_midwrite;
        int c1, c2;
        write_reg(8'hFE);
        enable = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        cfg_wdata = 8'hFC; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        clocks_to_done(1'b0, c1);
        chk(c1 + 4 == 2 * P, "R5 current period kept", c1 + 4, 2 * P);
        clocks_to_done(1'b0, c2);
        chk(c2 == 4 * P, "R5 new period applied", c2, 4 * P);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_disable_abort;
        int c;
        bit seen;
        write_reg(8'hF0);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(integrating == 1'b0, "R6 flag drops", int'(integrating), 0);
        seen = 0;
        repeat (100) begin
            @(negedge clk);
            if (done || integrating) seen = 1;
        end
        chk(!seen, "R6 no done while disabled", int'(seen), 0);
        enable = 1'b1;
        @(negedge clk);
        clocks_to_done(1'b0, c);
        chk(c == 16 * P, "R6 full period after reenable", c, 16 * P);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_gate_ignored;
        int c;
        write_reg(8'hFE);
        gate = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        clocks_to_done(1'b1, c);
        chk(c == 2 * P, "R9 gate ignored in auto", c, 2 * P);
        enable = 1'b0; gate = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_manual;
        write_reg(8'h00);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        chk(integrating == 1'b0, "R7 waits for gate", int'(integrating), 0);
        gate = 1'b1;
        @(negedge clk);
        chk(integrating == 1'b1, "R7 gate start", int'(integrating), 1);
        repeat (20) @(negedge clk);
        chk(integrating == 1'b1 && done == 1'b0, "R7 held while gate high", int'(integrating), 1);
        gate = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R8 done on gate fall", int'(done), 1);
        chk(integrating == 1'b0, "R8 flag falls", int'(integrating), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 one clock done", int'(done), 0);
        enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_manual_abort;
        bit seen;
        enable = 1'b1;
        gate = 1'b1;
        repeat (3) @(negedge clk);
        chk(integrating == 1'b1, "R10 manual running", int'(integrating), 1);
        enable = 1'b0;
        @(negedge clk);
        chk(integrating == 1'b0, "R10 abort flag", int'(integrating), 0);
        gate = 1'b0;
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(!seen, "R10 no done after abort", int'(seen), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_auto_period(8'hFF, "R3 0xFF one interval");
        t_auto_period(8'hFE, "R3 0xFE two intervals");
        t_auto_period(8'hED, "R3 0xED 19 intervals");
        t_auto_period(8'hDB, "R3 0xDB 37 intervals");
        t_auto_period(8'hB6, "R3 0xB6 74 intervals");
        t_auto_period(8'h6C, "R3 0x6C 148 intervals");
        t_auto_period(8'h01, "R3 0x01 255 intervals");
        t_midwrite();
        t_disable_abort();
        t_gate_ignored();
        t_manual();
        t_manual_abort();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule